// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the digital controller for an eight-channel successive-approximation converter. It picks which analog channel the converter core samples, launches each conversion with a one-clock start pulse, waits for the core to report completion and stores each 8-bit code in one of eight result slots. Each completion also carries a one-bit verdict from a reference comparator, and the sequencer files it as a per-channel compare flag. When the last slot of a cycle is written it raises a sticky interrupt flag.

A cycle can be launched in two ways. In internal mode, software sets the enable bit and cycles then run back to back until enable is cleared. In external mode, an active-low trigger is sampled once per machine-cycle strobe. It is level-sensitive, and one low sample launches exactly one cycle. Two orderings are offered. Scan order converts channels 0..7 into slots 0..7. Select order converts one chosen low channel four times into slots 0..3 and then channels 4..7 into slots 4..7.

The converter-core interface carries no back-pressure. The core must accept every start pulse. Done is a single-cycle pulse that is only taken while a conversion is outstanding. All other pins are plain level controls.

Top module: `adc_scan_seq`

## Requirements
- R1: Eight 8-bit result slots exist. Slot n sits at `res_flat[8n+7:8n]`. When a completion is accepted, the code is written only into the slot of the current conversion, and every other slot keeps its value.
- R2: With `cfg_sel_mode`=0, one cycle issues eight starts with `conv_ch` = 0,1,...,7 in that order. A new start is issued only after the done for the previous one has been accepted.
- R3: With `cfg_sel_mode`=1, the cycle issues `conv_ch` = sel,sel,sel,sel,4,5,6,7, where sel is the 2-bit `cfg_sel_ch`. The mode and the select value are captured when the cycle starts, so later changes to them do not affect that cycle.
- R4: For the k-th conversion of a cycle (k = 0..7), `conv_cmp_ch` equals k whatever the mode. On acceptance, `cmp_flags[k]` takes the value of `conv_above`.
- R5: In internal mode (`cfg_int_start`=1), `conv_start` is high one clock after enable is first sampled high. After slot 7 completes, the next cycle starts again at channel 0 / compare channel 0 for as long as enable stays high.
- R6: In external mode (`cfg_int_start`=0, enable high), a cycle starts only when `trig_n` is low on a clock where `mc_tick` is high. While a cycle is running, `trig_n` has no effect. After the cycle ends, no start occurs while `trig_n` is high.
- R7: Clearing `cfg_en` stops the sequence. No further start is issued, and a done that arrives afterwards changes no result or flag.
- R8: `conv_start` is never high for two clocks in a row. It is low while the sequencer is idle.
- R9: `irq_flag` is set on the clock that accepts the slot-7 completion. It stays set until `irq_clr` is asserted, and a set on the same clock as a clear wins. `irq_req` is high only while `irq_flag` and `cfg_en` are both high.
- R10: After reset, all slots, flags, `irq_flag`, `irq_req` and `conv_start` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe that qualifies trigger sampling |
| cfg_en | input | 1 | Converter enable |
| cfg_int_start | input | 1 | 1 = internal (continuous) start, 0 = external trigger |
| cfg_sel_mode | input | 1 | 1 = select order, 0 = scan order |
| cfg_sel_ch | input | 2 | Channel repeated in select order |
| trig_n | input | 1 | Active-low level trigger |
| conv_start | output | 1 | One-clock start pulse to the core |
| conv_ch | output | 3 | Multiplexer channel for the conversion |
| conv_cmp_ch | output | 3 | Channel the comparator verdict refers to |
| conv_done | input | 1 | Completion pulse from the core |
| conv_code | input | 8 | Conversion code, valid with done |
| conv_above | input | 1 | Comparator verdict, valid with done |
| res_flat | output | 64 | Eight result slots, slot n at bits 8n+7:8n |
| cmp_flags | output | 8 | Per-channel compare flags |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky end-of-cycle flag |
| irq_req | output | 1 | Interrupt request |

## Verification
A start pulse appears one clock after the condition that launches it (enable sampled, a trigger low at a tick, or an accepted done). A result slot, a compare flag and the interrupt flag change on the same edge that samples the done pulse. The bench drives its inputs and reads the outputs one time unit after each falling edge, so every value it reads was settled by the preceding rising edge. Checks are therefore placed at the first read point after the edge that should have acted. The core model raises done at least one falling edge after it sees a start. Because of that, each conversion is logged in order and its expected code is known before the slot is read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [0:0] {SQ_IDLE = 1'b0, SQ_BUSY = 1'b1} sq_state_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int REPEAT  = 4,
  parameter int SEL_W   = 2,
  localparam int SW     = $clog2(N_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick,
  input  logic             en,
  input  logic             int_mode,
  input  logic             sel_mode,
  input  logic [SEL_W-1:0] sel_ch,
  input  logic             trig_n,
  input  logic             conv_done,
  output logic             conv_start,
  output logic [SW-1:0]    conv_ch,
  output logic [SW-1:0]    conv_cmp_ch,
  output logic             wr_en,
  output logic [SW-1:0]    wr_slot,
  output logic             cycle_end
);
  localparam logic [SW-1:0] LAST  = SW'(N_SLOTS - 1);
  localparam logic [SW-1:0] REP_L = SW'(REPEAT);

  sq_state_t        st;
  logic [SW-1:0]    slot;
  logic             start_q;
  logic [SW-1:0]    ch_q;
  logic             smode_q;
  logic [SEL_W-1:0] sch_q;
  logic             accept;
  logic             launch;

  function automatic logic [SW-1:0] chan_for(input logic [SW-1:0] s,
                                             input logic sm,
                                             input logic [SEL_W-1:0] sc);
    if (sm && (s < REP_L)) return SW'(sc);
    return s;
  endfunction

  // a done is taken only while a conversion is outstanding
  assign accept    = (st == SQ_BUSY) && !start_q && conv_done && en;
  assign launch    = en && (int_mode || (mc_tick && !trig_n));
  assign wr_en     = accept;
  assign wr_slot   = slot;
  assign cycle_end = accept && (slot == LAST);

  assign conv_start  = start_q;
  assign conv_ch     = ch_q;
  assign conv_cmp_ch = slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      slot    <= '0;
      start_q <= 1'b0;
      ch_q    <= '0;
      smode_q <= 1'b0;
      sch_q   <= '0;
    end else begin
      start_q <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (launch) begin
            st      <= SQ_BUSY;
            slot    <= '0;
            smode_q <= sel_mode;
            sch_q   <= sel_ch;
            start_q <= 1'b1;
            ch_q    <= chan_for('0, sel_mode, sel_ch);
          end
        end
        SQ_BUSY: begin
          if (!en) begin
            st <= SQ_IDLE;
          end else if (accept) begin
            if (slot == LAST) begin
              st <= SQ_IDLE;
            end else begin
              slot    <= slot + 1'b1;
              start_q <= 1'b1;
              ch_q    <= chan_for(slot + 1'b1, smode_q, sch_q);
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  a_r8_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r8_idle_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE) |-> !conv_start);
  a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == SQ_IDLE));
  a_r2_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SQ_BUSY) && !conv_done) |=> $stable(slot));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int N_SLOTS = 8,
  parameter int RES_W   = 8,
  localparam int SW     = $clog2(N_SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SW-1:0]            wr_slot,
  input  logic [RES_W-1:0]         code,
  input  logic                     above,
  output logic [N_SLOTS*RES_W-1:0] res_flat,
  output logic [N_SLOTS-1:0]       cmp_flags
);
  logic [RES_W-1:0] res_q  [N_SLOTS];
  logic             flag_q [N_SLOTS];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[g]  <= '0;
        flag_q[g] <= 1'b0;
      end else if (wr_en && (wr_slot == SW'(g))) begin
        res_q[g]  <= code;
        flag_q[g] <= above;
      end
    end
    assign res_flat[g*RES_W +: RES_W] = res_q[g];
    assign cmp_flags[g]               = flag_q[g];
  end

  a_r1_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(res_flat) && $stable(cmp_flags)));
endmodule

// File: rtl/adc_irq_unit.sv
module adc_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic en,
  output logic flag,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (set_i) flag <= 1'b1;
    else if (clr_i) flag <= 1'b0;
  end

  assign req = flag && en;

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_i) |=> flag);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int N_SLOTS = 8,
  parameter int RES_W   = 8,
  parameter int REPEAT  = 4,
  parameter int SEL_W   = 2,
  localparam int SW     = $clog2(N_SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mc_tick,
  input  logic                     cfg_en,
  input  logic                     cfg_int_start,
  input  logic                     cfg_sel_mode,
  input  logic [SEL_W-1:0]         cfg_sel_ch,
  input  logic                     trig_n,
  output logic                     conv_start,
  output logic [SW-1:0]            conv_ch,
  output logic [SW-1:0]            conv_cmp_ch,
  input  logic                     conv_done,
  input  logic [RES_W-1:0]         conv_code,
  input  logic                     conv_above,
  output logic [N_SLOTS*RES_W-1:0] res_flat,
  output logic [N_SLOTS-1:0]       cmp_flags,
  input  logic                     irq_clr,
  output logic                     irq_flag,
  output logic                     irq_req
);
  logic          wr_en;
  logic [SW-1:0] wr_slot;
  logic          cycle_end;

  adc_seq_ctrl #(.N_SLOTS(N_SLOTS), .REPEAT(REPEAT), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .en(cfg_en),
    .int_mode(cfg_int_start), .sel_mode(cfg_sel_mode), .sel_ch(cfg_sel_ch),
    .trig_n(trig_n), .conv_done(conv_done), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_cmp_ch(conv_cmp_ch), .wr_en(wr_en),
    .wr_slot(wr_slot), .cycle_end(cycle_end)
  );

  adc_result_bank #(.N_SLOTS(N_SLOTS), .RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .code(conv_code), .above(conv_above), .res_flat(res_flat),
    .cmp_flags(cmp_flags)
  );

  adc_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .set_i(cycle_end), .clr_i(irq_clr),
    .en(cfg_en), .flag(irq_flag), .req(irq_req)
  );
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LOGN = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_tick = 1'b0;
  logic cfg_en = 1'b0, cfg_int_start = 1'b1, cfg_sel_mode = 1'b0;
  logic [1:0] cfg_sel_ch = '0;
  logic trig_n = 1'b1;
  logic conv_start;
  logic [2:0] conv_ch, conv_cmp_ch;
  logic conv_done = 1'b0;
  logic [7:0] conv_code = '0;
  logic conv_above = 1'b0;
  logic [63:0] res_flat;
  logic [7:0] cmp_flags;
  logic irq_clr = 1'b0;
  logic irq_flag, irq_req;

  adc_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cfg_en(cfg_en),
    .cfg_int_start(cfg_int_start), .cfg_sel_mode(cfg_sel_mode),
    .cfg_sel_ch(cfg_sel_ch), .trig_n(trig_n), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_cmp_ch(conv_cmp_ch), .conv_done(conv_done),
    .conv_code(conv_code), .conv_above(conv_above), .res_flat(res_flat),
    .cmp_flags(cmp_flags), .irq_clr(irq_clr), .irq_flag(irq_flag),
    .irq_req(irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int nlog = 0;
  logic [2:0] log_ch [LOGN];
  logic [2:0] log_cmp [LOGN];
  logic [7:0] log_code [LOGN];
  logic       log_abv [LOGN];

  // converter core model: done 1..3 falling edges after start
  bit core_pend = 0;
  int core_cnt = 0;
  logic [7:0] core_code;
  logic core_abv;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (core_pend) begin
      if (core_cnt == 0) begin
        conv_done = 1'b1; conv_code = core_code; conv_above = core_abv;
        core_pend = 0;
      end else core_cnt--;
    end
    if (conv_start) begin
      core_code = 8'($urandom);
      core_abv  = 1'($urandom);
      if (nlog < LOGN) begin
        log_ch[nlog] = conv_ch; log_cmp[nlog] = conv_cmp_ch;
        log_code[nlog] = core_code; log_abv[nlog] = core_abv;
      end
      nlog++;
      core_pend = 1; core_cnt = int'($urandom_range(2, 0));
    end
  end

  bit tick_on = 0;
  int tick_cnt = 0;
  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % 4;
    mc_tick = tick_on && (tick_cnt == 0);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog(all R) actual=%0d expected<%0d cycles", cyc, 150000);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  function automatic logic [2:0] exp_chan(input int s, input bit sm,
                                          input logic [1:0] sel);
    if (sm && s < 4) return {1'b0, sel};
    return 3'(s);
  endfunction

  task automatic check_cycle(input int base, input bit sm, input logic [1:0] sel);
    logic [7:0] ef;
    chk(nlog - base == 8, "R2 starts per cycle", 64'(nlog - base), 8);
    for (int s = 0; s < 8; s++) begin
      chk(log_ch[base+s] == exp_chan(s, sm, sel), sm ? "R3 select channel" : "R2 scan channel",
          64'(log_ch[base+s]), 64'(exp_chan(s, sm, sel)));
      chk(log_cmp[base+s] == 3'(s), "R4 compare channel", 64'(log_cmp[base+s]), 64'(s));
      chk(res_flat[8*s +: 8] == log_code[base+s], "R1 slot value",
          64'(res_flat[8*s +: 8]), 64'(log_code[base+s]));
      ef[s] = log_abv[base+s];
    end
    chk(cmp_flags == ef, "R4 compare flags", 64'(cmp_flags), 64'(ef));
  endtask

  task automatic run_one_cycle(input bit sm, input logic [1:0] sel, input bit scramble);
    int base, guard;
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    chk(irq_flag == 1'b0, "R9 clear", 64'(irq_flag), 0);
    cfg_int_start = 1'b1; cfg_sel_mode = sm; cfg_sel_ch = sel;
    base = nlog; cfg_en = 1'b1;
    step(1);
    chk(conv_start == 1'b1, "R5 start after enable", 64'(conv_start), 1);
    guard = 0;
    while (!irq_flag && guard < 300) begin
      step(1); guard++;
      if (scramble && nlog > base) begin
        cfg_sel_mode = 1'($urandom); cfg_sel_ch = 2'($urandom);
      end
    end
    chk(irq_req == 1'b1, "R9 request while enabled", 64'(irq_req), 1);
    cfg_en = 1'b0; step(1);
    chk(irq_req == 1'b0, "R9 request masked", 64'(irq_req), 0);
    chk(irq_flag == 1'b1, "R9 sticky", 64'(irq_flag), 1);
    step(3);
    check_cycle(base, sm, sel);
  endtask

  initial begin
    int base, guard;
    logic [63:0] snap;
    logic [7:0]  fsnap;
    int snapn;
    void'($urandom(32'd4242));
    step(3);
    chk(res_flat == '0, "R10 reset slots", res_flat, 0);
    chk(cmp_flags == '0, "R10 reset flags", 64'(cmp_flags), 0);
    chk(irq_flag == 1'b0 && irq_req == 1'b0, "R10 reset irq", 64'({irq_flag, irq_req}), 0);
    chk(conv_start == 1'b0, "R10 reset start", 64'(conv_start), 0);
    rst_n = 1'b1; step(2);
    chk(conv_start == 1'b0, "R8 idle without enable", 64'(conv_start), 0);

    // directed orderings
    run_one_cycle(1'b0, 2'd0, 1'b0);
    run_one_cycle(1'b1, 2'd2, 1'b0);
    run_one_cycle(1'b1, 2'd3, 1'b1);
    // random mix, config scrambled mid-cycle (R3 latching)
    for (int it = 0; it < 8; it++)
      run_one_cycle(1'($urandom), 2'($urandom), 1'($urandom));

    // continuous internal run, then abort (R5, R7)
    cfg_int_start = 1'b1; cfg_sel_mode = 1'b0; base = nlog; cfg_en = 1'b1;
    guard = 0;
    while (nlog < base + 11 && guard < 400) begin step(1); guard++; end
    chk(log_ch[base+8] == 3'd0 && log_cmp[base+8] == 3'd0, "R5 restart at channel 0",
        64'({log_ch[base+8], log_cmp[base+8]}), 0);
    chk(irq_flag == 1'b1, "R9 set in continuous run", 64'(irq_flag), 1);
    cfg_en = 1'b0;
    snap = res_flat; fsnap = cmp_flags; snapn = nlog;
    step(20);
    chk(nlog == snapn, "R7 no start after disable", 64'(nlog), 64'(snapn));
    chk(res_flat == snap, "R7 late done ignored", res_flat, snap);
    chk(cmp_flags == fsnap, "R7 flags untouched", 64'(cmp_flags), 64'(fsnap));

    // set beats clear on the same edge (R9)
    irq_clr = 1'b1; cfg_int_start = 1'b1; cfg_sel_mode = 1'b0; base = nlog; cfg_en = 1'b1;
    guard = 0;
    while (!(conv_done && nlog - base == 8) && guard < 300) begin step(1); guard++; end
    step(1);
    chk(irq_flag == 1'b1, "R9 set wins over clear", 64'(irq_flag), 1);
    cfg_en = 1'b0; step(1);
    chk(irq_flag == 1'b0, "R9 clear after set", 64'(irq_flag), 0);
    irq_clr = 1'b0; step(10);

    // external trigger (R6)
    cfg_int_start = 1'b0; trig_n = 1'b1; tick_on = 1; base = nlog; cfg_en = 1'b1;
    step(30);
    chk(nlog == base, "R6 no start with trigger high", 64'(nlog - base), 0);
    tick_on = 0; trig_n = 1'b0; step(12);
    chk(nlog == base, "R6 trigger needs machine tick", 64'(nlog - base), 0);
    tick_on = 1; guard = 0;
    while (nlog == base && guard < 20) begin step(1); guard++; end
    guard = 0;
    while (!irq_flag && guard < 300) begin
      trig_n = (nlog >= base + 7) ? 1'b1 : 1'($urandom);
      step(1); guard++;
    end
    trig_n = 1'b1; step(30);
    chk(nlog == base + 8, "R6 one cycle per trigger", 64'(nlog - base), 8);
    check_cycle(base, 1'b0, 2'd0);
    cfg_en = 1'b0; step(2);
    summary();
  end
endmodule